// File: doc/BRIEF.md
# ECC-Protected Simple Dual-Port RAM

This block is a simple dual-port memory with one write port and one read port, each holding 64-bit words. On every write the block encodes the word into a 72-bit codeword and stores it: 64 data bits, 7 Hamming check bits and one overall parity bit. On every read it computes a syndrome over the stored codeword. It repairs any single flipped bit. It reports a two-bit flip without changing the data. Each read result comes with a 3-bit error status.

A build-time parameter chooses how the status is delivered. It can be registered beside the read-data register, sharing its clock and asynchronous clear. It can also be combinational and valid in the read cycle itself, in which case the clear does not touch it. A test-only corruption port XORs a mask into one stored codeword, so error handling can be exercised through the normal read path. Every write stores a full word; there are no byte enables.

Top module: `secded_ram`

## Requirements
- R1: A write stores the full 64-bit word. A read with `rd_en` high presents that word on `rd_data` at the next rising edge, with status 000.
- R2: If exactly one of the 72 stored bits of the read word is flipped, `rd_data` returns the original word and the status is 011.
- R3: If exactly two stored bits are flipped, the status is 101 and `rd_data` carries the raw stored data bits uncorrected. Codeword layout: bit 0 is overall parity, bits 1, 2, 4, 8, 16, 32 and 64 are check bits, and data bit k sits at the (k+1)-th index in 1..71 that is not a power of two, in ascending order. A `inj_mask` bit i flips codeword bit i.
- R4: The status is only ever 000, 011 or 101.
- R5: With `REG_STATUS`=1, the status updates on the same edge as `rd_data`. While `clr` is high, both `rd_data` and the status are 0.
- R6: With `REG_STATUS`=0, the status describes the word selected by `rd_addr` during the cycle `rd_en` is high, and it is 000 while `rd_en` is low. `clr` has no effect on it.
- R7: A read and a write to the same address in the same cycle return the newly written word with status 000, never the old contents.
- R8: While `rd_en` is low, `rd_data` (and a registered status) hold their values.
- R9: A corruption persists across repeated reads until the address is rewritten. A write to the address clears it. If a write and a corruption target the same address in the same cycle, the write wins.
- R10: The memory contents are not cleared by `clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| clr | input | 1 | Asynchronous clear of the output registers, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 64 | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| inj_en | input | 1 | Test-only corruption strobe |
| inj_addr | input | ADDR_W | Address of the codeword to corrupt |
| inj_mask | input | 72 | Bits XORed into the stored codeword |
| rd_data | output | 64 | Registered read data after correction |
| err_status | output | 3 | 000 clean, 011 corrected, 101 double error |

## Verification
Read data and the registered status are due at the first rising edge after the cycle with `rd_en` high. The bench compares them 2 ns after every edge against a behavioural model that keeps each word beside a flip mask. The combinational status of a second instance is due within the read cycle. It is compared 1 ns before the closing edge, while the model still holds the memory state that the read sees. Inputs change only on falling edges, so every sample lands on settled values.

// File: rtl/secded_ram.sv
module secded_ram #(
  parameter int ADDR_W     = 4,
  parameter bit REG_STATUS = 1'b1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [71:0]       inj_mask,
  output logic [63:0]       rd_data,
  output logic [2:0]        err_status
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = 72;

  function automatic logic [CW-1:0] encode(input logic [63:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int i = 1; i < CW; i++)
      if ((i & (i - 1)) != 0) begin
        c[7'(i)] = d[6'(k)];
        k++;
      end
    for (int p = 0; p < 7; p++)
      for (int i = 1; i < CW; i++)
        if ((i & (i - 1)) != 0 && ((i >> p) & 1) == 1)
          c[7'(1 << p)] = c[7'(1 << p)] ^ c[7'(i)];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [63:0] extract(input logic [CW-1:0] c);
    logic [63:0] d;
    int k;
    d = '0;
    k = 0;
    for (int i = 1; i < CW; i++)
      if ((i & (i - 1)) != 0) begin
        d[6'(k)] = c[7'(i)];
        k++;
      end
    return d;
  endfunction

  function automatic logic [6:0] syndrome(input logic [CW-1:0] c);
    logic [6:0] s;
    s = '0;
    for (int i = 1; i < CW; i++)
      if (c[7'(i)]) s = s ^ 7'(i);
    return s;
  endfunction

  logic [CW-1:0] mem [DEPTH];
  logic [CW-1:0] rd_cw, fixed_cw;
  logic [6:0]    syn;
  logic          ovp;
  logic [2:0]    dec_status;
  logic [63:0]   dec_data;

  always_ff @(posedge clk) begin
    if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    if (wr_en)  mem[wr_addr]  <= encode(wr_data);
  end

  assign rd_cw = (wr_en && wr_addr == rd_addr) ? encode(wr_data) : mem[rd_addr];
  assign syn   = syndrome(rd_cw);
  assign ovp   = ^rd_cw;

  always_comb begin
    fixed_cw = rd_cw;
    if (ovp && syn < 7'd72) fixed_cw[syn] = ~rd_cw[syn];
    if (!ovp && syn == 7'd0)     dec_status = 3'b000;
    else if (ovp && syn < 7'd72) dec_status = 3'b011;
    else                         dec_status = 3'b101;
  end

  assign dec_data = extract(fixed_cw);

  always_ff @(posedge clk or posedge clr)
    if (clr)        rd_data <= '0;
    else if (rd_en) rd_data <= dec_data;

  generate
    if (REG_STATUS) begin : g_reg_status
      logic [2:0] status_q;
      always_ff @(posedge clk or posedge clr)
        if (clr)        status_q <= '0;
        else if (rd_en) status_q <= dec_status;
      assign err_status = status_q;

      assert_hold_status_R8: assert property (@(posedge clk) disable iff (clr)
        !rd_en |=> $stable(err_status));
      assert_forward_R7: assert property (@(posedge clk) disable iff (clr)
        (rd_en && wr_en && wr_addr == rd_addr) |=>
          (rd_data == $past(wr_data) && err_status == 3'b000));
    end else begin : g_comb_status
      assign err_status = rd_en ? dec_status : 3'b000;

      assert_idle_status_R6: assert property (@(posedge clk) disable iff (clr)
        !rd_en |-> err_status == 3'b000);
    end
  endgenerate

  assert_legal_status_R4: assert property (@(posedge clk) disable iff (clr)
    err_status == 3'b000 || err_status == 3'b011 || err_status == 3'b101);
  assert_hold_data_R8: assert property (@(posedge clk) disable iff (clr)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/secded_ram_test.sv
module secded_ram_test;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 0, clr = 1;
  logic wr_en = 0, rd_en = 0, inj_en = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0, inj_addr = 0;
  logic [63:0] wr_data = 0;
  logic [71:0] inj_mask = 0;
  logic [63:0] rd_data, rd_data_c;
  logic [2:0]  st, st_c;

  always #5 clk = ~clk;

  secded_ram #(.ADDR_W(AW), .REG_STATUS(1'b1)) uut (
    .clk, .clr, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr,
    .inj_en, .inj_addr, .inj_mask, .rd_data, .err_status(st));
  secded_ram #(.ADDR_W(AW), .REG_STATUS(1'b0)) uut_c (
    .clk, .clr, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr,
    .inj_en, .inj_addr, .inj_mask, .rd_data(rd_data_c), .err_status(st_c));

  int checks = 0, fails = 0;
  string req = "R5";
  logic [63:0] m_data [N];
  logic [71:0] m_flip [N];
  logic [63:0] exp_d = 0;
  logic [2:0]  exp_s = 0;

  function automatic logic [63:0] data_of(input logic [71:0] c);
    logic [63:0] d = 0;
    int k = 0;
    for (int i = 1; i < 72; i++)
      if ((i & (i - 1)) != 0) begin d[k] = c[i]; k++; end
    return d;
  endfunction

  task automatic model_read(output logic [63:0] d, output logic [2:0] s);
    if (wr_en && wr_addr == rd_addr) begin d = wr_data; s = 3'b000; end
    else begin
      int n = $countones(m_flip[rd_addr]);
      d = m_data[rd_addr];
      s = (n == 0) ? 3'b000 : (n == 1) ? 3'b011 : 3'b101;
      if (n >= 2) d = d ^ data_of(m_flip[rd_addr]);
    end
  endtask

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [63:0] d; logic [2:0] s;
    model_read(d, s);
    if (clr) begin exp_d = 0; exp_s = 0; end
    else if (rd_en) begin exp_d = d; exp_s = s; end
    if (inj_en) m_flip[inj_addr] = m_flip[inj_addr] ^ inj_mask;
    if (wr_en) begin m_data[wr_addr] = wr_data; m_flip[wr_addr] = 0; end
  end

  always @(posedge clk) begin
    #2;
    check("rd_data", rd_data, exp_d);
    check("status", 64'(st), 64'(exp_s));
    check("rd_data comb inst", rd_data_c, exp_d);
    checks++;
    if (!(st == 3'b000 || st == 3'b011 || st == 3'b101 || st_c == 3'b000 ||
          st_c == 3'b011 || st_c == 3'b101)) begin
      fails++;
      $display("FAIL R4 illegal status: actual %b/%b expected 000|011|101", st, st_c);
    end
  end

  always @(negedge clk) begin
    logic [63:0] d; logic [2:0] s;
    #4;
    model_read(d, s);
    check("comb status (R6)", 64'(st_c), rd_en ? 64'(s) : 64'd0);
  end

  task automatic cyc(bit we, int wa, logic [63:0] wd, bit re, int ra,
                     bit ie = 0, int ia = 0, logic [71:0] im = 0);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    rd_en = re; rd_addr = AW'(ra);
    inj_en = ie; inj_addr = AW'(ia); inj_mask = im;
  endtask

  function automatic logic [63:0] pat(int i);
    return {32'(i) * 32'h9E3779B9, ~(32'(i) * 32'h85EBCA6B)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R5: outputs cleared while clr is high
    repeat (3) cyc(0, 0, 0, 0, 0);
    @(negedge clk); clr = 0;
    // R1: fill and read back
    req = "R1";
    for (int i = 0; i < N; i++) cyc(1, i, pat(i), 0, 0);
    for (int i = 0; i < N; i++) cyc(0, 0, 0, 1, N - 1 - i);
    // R8: hold with rd_en low
    req = "R8";
    repeat (3) cyc(1, 2, pat(40), 0, 0);
    cyc(0, 0, 0, 1, 2);
    // R7: same-address read during write
    req = "R7";
    cyc(1, 5, 64'hDEAD_BEEF_0123_4567, 1, 5);
    cyc(1, 6, 64'hFFFF_FFFF_FFFF_FFFF, 1, 6);
    cyc(0, 0, 0, 1, 5);
    // R2: single flips at many positions
    req = "R2";
    for (int b = 0; b < 72; b += 7) begin
      cyc(1, 3, pat(b + 100), 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 3, 72'd1 << b);
      cyc(0, 0, 0, 1, 3);
    end
    cyc(0, 0, 0, 0, 0, 1, 4, 72'd1 << 71);
    cyc(0, 0, 0, 1, 4);
    // R9: persistence, rewrite clears, write beats corruption
    req = "R9";
    cyc(0, 0, 0, 1, 4);
    cyc(1, 4, pat(77), 1, 4);
    cyc(0, 0, 0, 1, 4);
    cyc(1, 7, pat(78), 0, 0, 1, 7, 72'h3);
    cyc(0, 0, 0, 1, 7);
    // R3: double flips, raw data out
    req = "R3";
    cyc(0, 0, 0, 0, 0, 1, 8, (72'd1 << 3) | (72'd1 << 5));
    cyc(0, 0, 0, 1, 8);
    cyc(0, 0, 0, 0, 0, 1, 9, (72'd1 << 0) | (72'd1 << 64));
    cyc(0, 0, 0, 1, 9);
    cyc(0, 0, 0, 0, 0, 1, 10, (72'd1 << 70) | (72'd1 << 12));
    cyc(0, 0, 0, 1, 10);
    // R6 and R10: clr mid-run leaves memory and comb status alone
    req = "R6";
    cyc(0, 0, 0, 1, 8);
    clr = 1;
    cyc(0, 0, 0, 1, 9);
    cyc(0, 0, 0, 1, 3);
    @(negedge clk); clr = 0;
    req = "R10";
    cyc(0, 0, 0, 1, 11);
    cyc(0, 0, 0, 1, 8);
    cyc(0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule